// File: doc/BRIEF.md
# Modem Status Scanner for Sixteen Serial Lines

The block holds the modem control outputs of sixteen serial lines and watches their modem inputs. For each line it drives line enable, data terminal ready, request to send and secondary transmit. It samples four inputs per line: carrier, clear to send, secondary receive and ring. While scanning is on, a pointer visits one line per clock. It compares that line's inputs with a stored copy taken on the previous visit. When a compared signal has changed, the scanner halts on that line. It then reports the line number and one flag per changed signal, sets a done bit, and raises an interrupt if interrupts are enabled.

Software uses two 16-bit registers, picked by a one-bit register select. The control register starts, stops, steps and clears the scanner and shows its state. The line-status register shows the outputs and the sampled inputs of the line whose number is in the control register. Before selecting a line, software first clears scan enable and waits until the busy bit reads 0. A maintenance setting loops each line's outputs back onto its own inputs.

Top module: `mdm_scanner`

## Requirements
- R1: After reset, both registers read 0x0000, all line outputs are 0 and the interrupt output is 0.
- R2: A line-status write loads bits 3:0 into the selected line's outputs (bit 0 line enable, bit 1 DTR, bit 2 RTS, bit 3 secondary transmit) and leaves every other line alone. Written bits 7:4 are ignored. A line-status read returns those outputs in bits 3:0 and the sampled inputs in bits 7:4 (bit 4 secondary receive, bit 5 CTS, bit 6 carrier, bit 7 ring).
- R3: With scan enable (control bit 5) set, one line is compared per clock and the pointer wraps from 15 to 0. A change on carrier, CTS or secondary receive stops the scan on that line. At the stop, the line number is in control bits 3:0, done (bit 7) is set, and the change flags are set: bit 12 secondary receive, bit 13 CTS, bit 14 carrier.
- R4: A rising ring input stops the scan with flag bit 15 set. A falling ring input updates the stored copy without stopping the scan or setting any flag.
- R5: Control bit 4 (busy) reads 1 in the cycle after a comparison took place. After a write clears scan enable, busy reads 1 for exactly one more cycle and then 0.
- R6: A control write with bit 5 set clears done and all change flags and resumes scanning. A change already reported is not reported again.
- R7: The interrupt output equals done AND interrupt enable (bit 6). A control write with bits 7 and 6 both set raises it at once.
- R8: A control write with bit 8 set and bit 5 clear performs exactly one comparison, on the written line, on the next clock. Bit 8 always reads 0.
- R9: While maintenance (bit 9) is set, each line's inputs are taken from its own outputs: ring from line enable, carrier from DTR, CTS from RTS and secondary receive from secondary transmit. External inputs are then ignored.
- R10: A control write with bit 11 set clears the line number, scan enable, done and flags, and keeps the line outputs. Bit 10 does the same and also clears every line output.
- R11: Change flags are never nonzero while done is 0. A control write that leaves done at 0 clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 line status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| car_in | input | 16 | Carrier detect, one bit per line |
| cts_in | input | 16 | Clear to send, one bit per line |
| srx_in | input | 16 | Secondary receive, one bit per line |
| ring_in | input | 16 | Ring indicator, one bit per line |
| le_out | output | 16 | Line enable, one bit per line |
| dtr_out | output | 16 | Data terminal ready, one bit per line |
| rts_out | output | 16 | Request to send, one bit per line |
| stx_out | output | 16 | Secondary transmit, one bit per line |

## Verification
The assertions assume that the modem inputs are already synchronous to the clock and hold steady around each edge. They also assume at most one register write per cycle and a line count that is a power of two. They do not assume software waits for busy before selecting a line. The write priority rules are checked only through the hold and clear properties. The bench changes the modem inputs and the bus signals only on the falling edge, issues one write at a time, and follows the stop-then-wait protocol before each line selection.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned B_BUSY    = 4;
  localparam int unsigned B_SCAN    = 5;
  localparam int unsigned B_IE      = 6;
  localparam int unsigned B_DONE    = 7;
  localparam int unsigned B_STEP    = 8;
  localparam int unsigned B_MAINT   = 9;
  localparam int unsigned B_CLRMUX  = 10;
  localparam int unsigned B_CLRSCAN = 11;
  localparam int unsigned B_FLAG0   = 12;

  // sampled inputs; packed order matches status bits 7:4
  typedef struct packed {
    logic ring;
    logic car;
    logic cts;
    logic srx;
  } mdm_in_t;

  // driven outputs; packed order matches status bits 3:0
  typedef struct packed {
    logic stx;
    logic rts;
    logic dtr;
    logic len;
  } mdm_out_t;

  // maintenance loopback of a line's outputs onto its inputs
  function automatic mdm_in_t loop_back(mdm_out_t o);
    mdm_in_t r;
    r.ring = o.len;
    r.car  = o.dtr;
    r.cts  = o.rts;
    r.srx  = o.stx;
    return r;
  endfunction

  // {ring rise, carrier change, cts change, srx change}
  function automatic logic [3:0] change_flags(mdm_in_t cur, mdm_in_t old);
    return {cur.ring & ~old.ring, cur.car ^ old.car, cur.cts ^ old.cts, cur.srx ^ old.srx};
  endfunction
endpackage

// File: rtl/mdm_line_bank.sv
module mdm_line_bank
  import mdm_pkg::*;
#(
  parameter int unsigned LINES = 16,
  localparam int unsigned SW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    sel,
  input  logic             ls_wr,
  input  mdm_out_t         ls_wdata,
  input  logic             clr_outs,
  input  logic             maint,
  input  logic             cmp_en,
  input  logic [LINES-1:0] ring_in,
  input  logic [LINES-1:0] car_in,
  input  logic [LINES-1:0] cts_in,
  input  logic [LINES-1:0] srx_in,
  output logic [LINES-1:0] le_o,
  output logic [LINES-1:0] dtr_o,
  output logic [LINES-1:0] rts_o,
  output logic [LINES-1:0] stx_o,
  output mdm_out_t         sel_out,
  output mdm_in_t          sel_in,
  output logic [3:0]       sel_flags
);
  logic [LINES-1:0][3:0] out_pk;
  logic [LINES-1:0][3:0] eff_pk;
  logic [LINES-1:0][3:0] copy_pk;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    mdm_out_t out_q;
    mdm_in_t  copy_q;
    mdm_in_t  eff;
    logic     hit_sel;

    assign hit_sel = (sel == SW'(i));
    assign eff = maint ? loop_back(out_q)
                       : mdm_in_t'({ring_in[i], car_in[i], cts_in[i], srx_in[i]});

    always_ff @(posedge clk) begin
      if (!rst_n)                 out_q <= '0;
      else if (clr_outs)          out_q <= '0;
      else if (ls_wr && hit_sel)  out_q <= ls_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                 copy_q <= '0;
      else if (cmp_en && hit_sel) copy_q <= eff;
    end

    assign out_pk[i]  = out_q;
    assign eff_pk[i]  = eff;
    assign copy_pk[i] = copy_q;
    assign le_o[i]    = out_q.len;
    assign dtr_o[i]   = out_q.dtr;
    assign rts_o[i]   = out_q.rts;
    assign stx_o[i]   = out_q.stx;
  end

  assign sel_out   = mdm_out_t'(out_pk[sel]);
  assign sel_in    = mdm_in_t'(eff_pk[sel]);
  assign sel_flags = change_flags(sel_in, mdm_in_t'(copy_pk[sel]));

  assert_outputs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_wr || clr_outs) |=> $stable(out_pk));

  assert_mux_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_outs |=> (out_pk == '0));

  assert_copy_after_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !maint && !ls_wr && !clr_outs) |=> $stable(sel) || (copy_pk[$past(sel)] == $past(eff_pk[sel])));
endmodule

// File: rtl/mdm_scan_ctrl.sv
module mdm_scan_ctrl
  import mdm_pkg::*;
#(
  parameter int unsigned LINES = 16,
  localparam int unsigned SW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [3:0]       sel_flags,
  output logic [SW-1:0]    sel,
  output logic             cmp_en,
  output logic             clr_outs,
  output logic             maint,
  output logic [REG_W-1:0] ctrl_rd,
  output logic             irq
);
  logic [SW-1:0] sel_q;
  logic          scan_q, ie_q, done_q, step_q, maint_q, busy_q;
  logic [3:0]    flags_q;
  logic          scanning, clr_scan, hit, wr_done;

  function automatic logic [SW-1:0] next_line(logic [SW-1:0] cur);
    return (cur == SW'(LINES - 1)) ? '0 : cur + 1'b1;
  endfunction

  assign scanning = (scan_q | step_q) & ~done_q;
  assign cmp_en   = scanning & ~ctl_wr;
  assign hit      = cmp_en & (|sel_flags);
  assign clr_outs = ctl_wr & wdata[B_CLRMUX];
  assign clr_scan = ctl_wr & (wdata[B_CLRSCAN] | wdata[B_CLRMUX]);
  assign wr_done  = wdata[B_DONE] & ~wdata[B_SCAN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0; scan_q <= 1'b0; ie_q <= 1'b0; done_q <= 1'b0;
      step_q <= 1'b0; maint_q <= 1'b0; busy_q <= 1'b0; flags_q <= '0;
    end else begin
      busy_q <= scanning;
      if (clr_scan) begin
        sel_q   <= '0;
        scan_q  <= 1'b0;
        step_q  <= 1'b0;
        done_q  <= 1'b0;
        flags_q <= '0;
        ie_q    <= wdata[B_IE];
        maint_q <= wdata[B_MAINT];
      end else if (ctl_wr) begin
        sel_q   <= wdata[SW-1:0];
        scan_q  <= wdata[B_SCAN];
        step_q  <= wdata[B_STEP];
        ie_q    <= wdata[B_IE];
        maint_q <= wdata[B_MAINT];
        done_q  <= wr_done;
        if (!wr_done) flags_q <= '0;
      end else if (cmp_en) begin
        step_q <= 1'b0;
        if (hit) begin
          done_q  <= 1'b1;
          flags_q <= sel_flags;
        end else begin
          sel_q <= next_line(sel_q);
        end
      end
    end
  end

  always_comb begin
    ctrl_rd                     = '0;
    ctrl_rd[SW-1:0]             = sel_q;
    ctrl_rd[B_BUSY]             = busy_q;
    ctrl_rd[B_SCAN]             = scan_q;
    ctrl_rd[B_IE]               = ie_q;
    ctrl_rd[B_DONE]             = done_q;
    ctrl_rd[B_MAINT]            = maint_q;
    ctrl_rd[B_FLAG0+3:B_FLAG0]  = flags_q;
  end

  assign sel   = sel_q;
  assign maint = maint_q;
  assign irq   = done_q & ie_q;

  assert_flags_need_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0) |-> done_q);

  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !scanning |=> !busy_q);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && !hit) |=> (sel_q == next_line($past(sel_q))));

  assert_stop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !ctl_wr) |=> ($stable(sel_q) && done_q));

  assert_stop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done_q) && !$past(ctl_wr)) |-> (flags_q != '0));

  assert_step_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && cmp_en) |=> !step_q);
endmodule

// File: rtl/mdm_scanner.sv
module mdm_scanner
  import mdm_pkg::*;
#(
  parameter int unsigned LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             irq,
  input  logic [LINES-1:0] car_in,
  input  logic [LINES-1:0] cts_in,
  input  logic [LINES-1:0] srx_in,
  input  logic [LINES-1:0] ring_in,
  output logic [LINES-1:0] le_out,
  output logic [LINES-1:0] dtr_out,
  output logic [LINES-1:0] rts_out,
  output logic [LINES-1:0] stx_out
);
  localparam int unsigned SW = $clog2(LINES);

  logic [SW-1:0]    sel;
  logic             ctl_wr, ls_wr, cmp_en, clr_outs, maint;
  logic [REG_W-1:0] ctrl_rd;
  logic [3:0]       sel_flags;
  mdm_out_t         sel_out;
  mdm_in_t          sel_in;

  assign ctl_wr = bus_wr & ~bus_sel;
  assign ls_wr  = bus_wr &  bus_sel;

  mdm_scan_ctrl #(.LINES(LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(bus_wdata),
    .sel_flags(sel_flags), .sel(sel), .cmp_en(cmp_en), .clr_outs(clr_outs),
    .maint(maint), .ctrl_rd(ctrl_rd), .irq(irq)
  );

  mdm_line_bank #(.LINES(LINES)) u_bank (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ls_wr(ls_wr),
    .ls_wdata(mdm_out_t'(bus_wdata[3:0])), .clr_outs(clr_outs), .maint(maint),
    .cmp_en(cmp_en), .ring_in(ring_in), .car_in(car_in), .cts_in(cts_in),
    .srx_in(srx_in), .le_o(le_out), .dtr_o(dtr_out), .rts_o(rts_out),
    .stx_o(stx_out), .sel_out(sel_out), .sel_in(sel_in), .sel_flags(sel_flags)
  );

  assign bus_rdata = bus_sel ? {8'h00, sel_in, sel_out} : ctrl_rd;

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[B_DONE] && bus_wdata[B_IE] && !bus_wdata[B_SCAN]
     && !bus_wdata[B_CLRSCAN] && !bus_wdata[B_CLRMUX]) |=> irq);
endmodule

// File: tb/mdm_scanner_bench.sv
module mdm_scanner_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_sel = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  logic [15:0] car_in = '0, cts_in = '0, srx_in = '0, ring_in = '0;
  logic [15:0] le_out, dtr_out, rts_out, stx_out;

  int checks = 0, failures = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  mdm_scanner u_mdm_scanner (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .car_in(car_in), .cts_in(cts_in), .srx_in(srx_in), .ring_in(ring_in),
    .le_out(le_out), .dtr_out(dtr_out), .rts_out(rts_out), .stx_out(stx_out)
  );

  // behavioural reference model
  logic [3:0] m_out [16];
  logic [3:0] m_copy [16];
  int   m_sel;
  bit   m_scan, m_ie, m_done, m_step, m_maint, m_busy;
  logic [3:0] m_flags;

  function automatic logic [3:0] m_eff(int l);
    if (m_maint) return {m_out[l][0], m_out[l][1], m_out[l][2], m_out[l][3]};
    return {ring_in[l], car_in[l], cts_in[l], srx_in[l]};
  endfunction

  function automatic logic [15:0] m_read(bit a);
    if (a) return {8'h00, m_eff(m_sel), m_out[m_sel]};
    return {m_flags, 2'b00, m_maint, 1'b0, m_done, m_ie, m_scan, m_busy, 4'(m_sel)};
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 16; i++) begin m_out[i] = '0; m_copy[i] = '0; end
    m_sel = 0; m_scan = 0; m_ie = 0; m_done = 0; m_step = 0; m_maint = 0;
    m_busy = 0; m_flags = '0;
  endtask

  task automatic m_update();
    bit run;
    int s0;
    logic [3:0] e, c, f;
    if (!rst_n) begin m_reset(); return; end
    run = (m_scan || m_step) && !m_done;
    s0 = m_sel;
    e = m_eff(s0);
    c = m_copy[s0];
    f = {e[3] & ~c[3], e[2] ^ c[2], e[1] ^ c[1], e[0] ^ c[0]};
    m_busy = run;
    if (bus_wr && bus_sel) m_out[s0] = bus_wdata[3:0];
    if (bus_wr && !bus_sel) begin
      if (bus_wdata[10]) for (int i = 0; i < 16; i++) m_out[i] = '0;
      if (bus_wdata[10] || bus_wdata[11]) begin
        m_sel = 0; m_scan = 0; m_step = 0; m_done = 0; m_flags = '0;
        m_ie = bus_wdata[6]; m_maint = bus_wdata[9];
      end else begin
        m_sel = bus_wdata[3:0]; m_scan = bus_wdata[5]; m_step = bus_wdata[8];
        m_ie = bus_wdata[6]; m_maint = bus_wdata[9];
        m_done = bus_wdata[7] && !bus_wdata[5];
        if (!m_done) m_flags = '0;
      end
    end else if (run) begin
      m_copy[s0] = e;
      m_step = 0;
      if (f != 0) begin m_done = 1; m_flags = f; end
      else m_sel = (s0 + 1) % 16;
    end
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] le_e, dtr_e, rts_e, stx_e;
    for (int i = 0; i < 16; i++) begin
      le_e[i] = m_out[i][0]; dtr_e[i] = m_out[i][1];
      rts_e[i] = m_out[i][2]; stx_e[i] = m_out[i][3];
    end
    check({cur_req, " model le_out"}, le_out, le_e);
    check({cur_req, " model dtr_out"}, dtr_out, dtr_e);
    check({cur_req, " model rts_out"}, rts_out, rts_e);
    check({cur_req, " model stx_out"}, stx_out, stx_e);
    check({cur_req, " model irq"}, 16'(irq), 16'(m_done && m_ie));
    check({cur_req, " model rdata"}, bus_rdata, m_read(bus_sel));
  endtask

  task automatic cyc();
    @(posedge clk);
    m_update();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(bit a, logic [15:0] d);
    bus_wr = 1'b1; bus_sel = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit a, logic [15:0] exp, string req);
    bus_sel = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired (R1 run incomplete) actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    m_reset();
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    cur_req = "R1";
    rd(0, 16'h0000, "R1 control after reset");
    rd(1, 16'h0000, "R1 status after reset");
    check("R1 dtr after reset", dtr_out, 16'h0000);
    check("R1 irq after reset", 16'(irq), 16'h0000);

    // R2 line-status access
    cur_req = "R2";
    wr(0, 16'h0005);
    wr(1, 16'h00F3);
    rd(1, 16'h0003, "R2 status write ignores 7:4");
    check("R2 le only line 5", le_out, 16'h0020);
    check("R2 dtr only line 5", dtr_out, 16'h0020);
    car_in[5] = 1'b1;
    cyc();
    rd(1, 16'h0043, "R2 carrier sample in bit 6");

    // R3 scan stops on carrier change
    cur_req = "R3";
    wr(0, 16'h0020);
    repeat (20) cyc();
    rd(0, 16'h40A5, "R3 stop on line 5 carrier");
    check("R7 no irq without enable", 16'(irq), 16'h0000);

    // R6 resume; R7 irq with enable
    cur_req = "R6";
    wr(0, 16'h0060);
    cts_in[9] = 1'b1;
    repeat (20) cyc();
    rd(0, 16'h20E9, "R6 resume and stop on line 9 cts");
    check("R7 irq raised on stop", 16'(irq), 16'h0001);

    // R4 ring rise and fall
    cur_req = "R4";
    wr(0, 16'h0020);
    ring_in[2] = 1'b1;
    repeat (20) cyc();
    rd(0, 16'h80A2, "R4 ring rise stop on line 2");
    ring_in[2] = 1'b0;
    wr(0, 16'h0020);
    repeat (40) cyc();
    rd(0, bus_rdata, "R4 read");
    check("R4 ring fall does not stop", 16'(bus_rdata[7]), 16'h0000);
    srx_in[12] = 1'b1;
    repeat (20) cyc();
    rd(0, 16'h10AC, "R3 stop on line 12 srx");

    // R5 busy behaviour
    cur_req = "R5";
    wr(0, 16'h0020);
    repeat (3) cyc();
    rd(0, bus_rdata, "R5 read");
    check("R5 busy while scanning", 16'(bus_rdata[4]), 16'h0001);
    wr(0, 16'h0000);
    rd(0, 16'h0010, "R5 busy one cycle after stop");
    cyc();
    rd(0, 16'h0000, "R5 busy cleared");

    // R7 probe
    cur_req = "R7";
    wr(0, 16'h00C0);
    rd(0, 16'h00C0, "R7 done written");
    check("R7 probe irq", 16'(irq), 16'h0001);
    wr(0, 16'h0000);
    check("R7 irq cleared", 16'(irq), 16'h0000);

    // R8 single step
    cur_req = "R8";
    car_in[7] = 1'b1;
    wr(0, 16'h0106);
    cyc(); cyc();
    rd(0, 16'h0007, "R8 one step no change advances");
    wr(0, 16'h0107);
    cyc(); cyc();
    rd(0, 16'h4087, "R8 step finds line 7 carrier");

    // R11 flags cleared with done
    cur_req = "R11";
    wr(0, 16'h0007);
    rd(0, 16'h0007, "R11 done write 0 clears flags");

    // R9 maintenance loopback
    cur_req = "R9";
    wr(0, 16'h0203);
    wr(1, 16'h000F);
    rd(1, 16'h00FF, "R9 loopback status");
    wr(0, 16'h0220);
    repeat (10) cyc();
    rd(0, 16'hF2A3, "R9 loopback stop on line 3");

    // R10 clears
    cur_req = "R10";
    wr(0, 16'h0800);
    rd(0, 16'h0000, "R10 clear scan");
    check("R10 clear scan keeps dtr", dtr_out, 16'h0028);
    wr(0, 16'h0400);
    check("R10 clear mux le", le_out, 16'h0000);
    check("R10 clear mux dtr", dtr_out, 16'h0000);
    check("R10 clear mux rts", rts_out, 16'h0000);
    check("R10 clear mux stx", stx_out, 16'h0000);
    cyc();
    finish_run();
  end
endmodule